// File: doc/BRIEF.md
# MSI Snooping Cache Line Controller

This block keeps the coherence state of a small direct-mapped cache that uses writeback and invalidation on a snooping bus. Every line holds one of three states (Invalid, Shared, Modified) and a stored tag. The processor side presents one read or write at a time. The controller answers hits at once. For a miss, a write to a clean copy, or the eviction of a dirty line, it raises a bus request and waits for a grant.

The snoop side watches transactions that other caches place on the bus. When a snoop targets a line held Modified, the controller signals a flush in the same cycle so that memory and the requester can both take the dirty data. It then lowers the line's state. A snoop that invalidates a Shared line needs no data. Snoops are serviced in every cycle, including while a processor request is waiting for the bus.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `cpu_done` are low, and no snoop hits (stored tags reset to zero, so a snoop to tag 0 must still miss).
- R2: A processor read that misses issues a bus read (`bus_op` = 1) for the request address. `cpu_done` is high in the grant cycle, and afterwards the line is Shared.
- R3: A processor write to a line that is Invalid or Shared issues a read-to-own (`bus_op` = 2) for the request address. `cpu_done` is high in the grant cycle, and afterwards the line is Modified.
- R4: A read to a Shared or Modified line, and a write to a Modified line, raise `cpu_done` in the cycle of the request with no bus request.
- R5: A snooped bus read (`snp_op` = 1) that hits a Modified line raises `snp_flush` and `snp_hit` in the same cycle and leaves the line Shared.
- R6: When parameter `RD_FLUSH_INVALIDATES` is 1, a snooped bus read on a Modified line flushes and leaves the line Invalid.
- R7: A snooped read-to-own (`snp_op` = 2) leaves a hit line Invalid. It flushes when the line was Modified and does not flush when it was Shared.
- R8: A snooped bus read on a Shared line reports a hit with no flush and leaves the line Shared.
- R9: A snoop with a tag mismatch, to an Invalid line, or with `snp_op` 0 or 3, gives no hit and no flush and changes no state.
- R10: A request whose index holds a Modified line with another tag first issues a writeback (`bus_op` = 3) with the victim address, without `cpu_done`, and then the miss transaction. Replacing a Shared line issues no writeback.
- R11: While a bus request waits for `bus_gnt`, `bus_req`, `bus_op` and `bus_addr` hold and `cpu_done` stays low.
- R12: Snoops are serviced while a request is pending. If a snoop removes the Modified state of a victim before its writeback is granted, the writeback is withdrawn and the request goes on with its miss transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until `cpu_done` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address {tag, index} |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_op | output | 2 | 0 none, 1 read, 2 read-to-own, 3 writeback |
| bus_addr | output | ADDR_W | Line address of the bus transaction |
| bus_gnt | input | 1 | Grant; the transaction takes place in this cycle |
| snp_valid | input | 1 | Snooped transaction valid (never in a cycle of own grant) |
| snp_op | input | 2 | Snooped operation, same encoding as `bus_op` |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_hit | output | 1 | Snoop found a valid copy |
| snp_flush | output | 1 | This cache supplies dirty data for the snoop |

## Verification
The hardest situation to reach from the ports is a snoop that lands on a dirty victim while its writeback is still waiting for the grant. The bench builds this on purpose. It makes a line Modified, then requests another tag at the same index and withholds the grant. During the wait it snoops the victim, and it then checks that the flush appears, that the request drops and that a plain read follows. Random traffic over three tags and four indices, with random grant delays, produces many more evictions and snoop collisions. It is checked against a reference state table kept in the bench.

// File: rtl/msi_pkg.sv
// Shared types for the MSI line controller: line states and bus operation codes.
package msi_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_RDX  = 2'd2,
        OP_WB   = 2'd3
    } bus_op_t;
endpackage

// File: rtl/msi_tag_store.sv
// State and tag storage for a direct-mapped array of lines.
// Two read ports (request side, snoop side). Two write ports: port A (request
// side, state and tag) has priority over port B (snoop side, state only).
// Assumes the two writers never target one line in the same cycle.
module msi_tag_store
    import msi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output line_st_t         ra_st,
    output logic [TAG_W-1:0] ra_tag,
    input  logic [IDX_W-1:0] rb_idx,
    output line_st_t         rb_st,
    output logic [TAG_W-1:0] rb_tag,
    input  logic             wa_en,
    input  logic [IDX_W-1:0] wa_idx,
    input  line_st_t         wa_st,
    input  logic [TAG_W-1:0] wa_tag,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  line_st_t         wb_st
);
    localparam int LINES = 1 << IDX_W;

    line_st_t         st_vec  [LINES];
    logic [TAG_W-1:0] tag_vec [LINES];

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            line_st_t         st_r;
            logic [TAG_W-1:0] tag_r;

            // Per-line state and tag register with write-port priority.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_r  <= LN_INV;
                    tag_r <= '0;
                end else if (wa_en && wa_idx == IDX_W'(g)) begin
                    st_r  <= wa_st;
                    tag_r <= wa_tag;
                end else if (wb_en && wb_idx == IDX_W'(g)) begin
                    st_r  <= wb_st;
                end
            end

            assign st_vec[g]  = st_r;
            assign tag_vec[g] = tag_r;
        end
    endgenerate

    assign ra_st  = st_vec[ra_idx];
    assign ra_tag = tag_vec[ra_idx];
    assign rb_st  = st_vec[rb_idx];
    assign rb_tag = tag_vec[rb_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
// Snoop decision: compares a snooped transaction with the addressed line and
// produces hit, flush and the state update. Purely combinational.
// FLUSH_TO_INV selects the policy for a snooped read on a Modified line.
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W        = 9,
    parameter bit FLUSH_TO_INV = 1'b0
) (
    input  logic             snp_valid,
    input  bus_op_t          snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             hit,
    output logic             flush,
    output logic             upd_en,
    output line_st_t         upd_st
);
    line_st_t rd_mod_next;

    generate
        if (FLUSH_TO_INV) begin : g_rd_inv
            assign rd_mod_next = LN_INV;
        end else begin : g_rd_shr
            assign rd_mod_next = LN_SHR;
        end
    endgenerate

    // Hit detection and next state for the snooped line.
    always_comb begin
        hit    = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag)
                 && (snp_op == OP_RD || snp_op == OP_RDX);
        flush  = hit && (line_st == LN_MOD);
        upd_en = 1'b0;
        upd_st = line_st;
        if (hit) begin
            if (snp_op == OP_RDX) begin
                upd_en = 1'b1;
                upd_st = LN_INV;
            end else if (line_st == LN_MOD) begin
                upd_en = 1'b1;
                upd_st = rd_mod_next;
            end
        end
    end
endmodule

// File: rtl/msi_req_fsm.sv
// Processor-side sequencer. Answers hits at once; otherwise holds one bus
// transaction (writeback of a dirty victim, then read or read-to-own) until
// granted. Assumes cpu_req/cpu_wr/cpu_addr stay stable until cpu_done and that
// no snoop arrives in the cycle of its own grant.
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_wr,
    input  logic [ADDR_W-1:0]       cpu_addr,
    output logic                    cpu_done,
    output logic [IDX_W-1:0]        look_idx,
    input  line_st_t                line_st,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic                    bus_gnt,
    output logic                    bus_req,
    output bus_op_t                 bus_op,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic                    wr_en,
    output line_st_t                wr_st,
    output logic [ADDR_W-IDX_W-1:0] wr_tag
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef enum logic {F_IDLE, F_BUS} fsm_t;

    fsm_t              fsm_q, fsm_d;
    bus_op_t           op_q, op_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [TAG_W-1:0]  cpu_tag;
    logic              tag_eq;
    logic              cancel;

    assign cpu_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign tag_eq   = (line_tag == cpu_tag);
    assign look_idx = (fsm_q == F_BUS) ? addr_q[IDX_W-1:0] : cpu_addr[IDX_W-1:0];
    assign bus_addr = addr_q;
    assign bus_op   = bus_req ? op_q : OP_NONE;

    // Next-state, completion and array-write decisions.
    always_comb begin
        fsm_d    = fsm_q;
        op_d     = op_q;
        addr_d   = addr_q;
        cpu_done = 1'b0;
        bus_req  = 1'b0;
        wr_en    = 1'b0;
        wr_st    = line_st;
        wr_tag   = line_tag;
        cancel   = 1'b0;
        case (fsm_q)
            F_IDLE: begin
                if (cpu_req) begin
                    if (tag_eq && line_st != LN_INV && (!cpu_wr || line_st == LN_MOD)) begin
                        cpu_done = 1'b1;
                    end else begin
                        fsm_d = F_BUS;
                        if (!tag_eq && line_st == LN_MOD) begin
                            op_d   = OP_WB;
                            addr_d = {line_tag, cpu_addr[IDX_W-1:0]};
                        end else begin
                            if (cpu_wr) op_d = OP_RDX;
                            else        op_d = OP_RD;
                            addr_d = cpu_addr;
                        end
                    end
                end
            end
            default: begin
                cancel = (op_q == OP_WB) && (line_st != LN_MOD);
                if (cancel) begin
                    fsm_d = F_IDLE;
                end else begin
                    bus_req = 1'b1;
                    if (bus_gnt) begin
                        fsm_d = F_IDLE;
                        wr_en = 1'b1;
                        case (op_q)
                            OP_WB:   wr_st = LN_INV;
                            OP_RD:   begin wr_st = LN_SHR; wr_tag = addr_q[ADDR_W-1:IDX_W]; end
                            default: begin wr_st = LN_MOD; wr_tag = addr_q[ADDR_W-1:IDX_W]; end
                        endcase
                        cpu_done = (op_q != OP_WB);
                    end
                end
            end
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q  <= F_IDLE;
            op_q   <= OP_NONE;
            addr_q <= '0;
        end else begin
            fsm_q  <= fsm_d;
            op_q   <= op_d;
            addr_q <= addr_d;
        end
    end
endmodule

// File: rtl/msi_line_ctrl.sv
// Top of the MSI coherence controller: joins the line store, the request
// sequencer and the snoop unit. Snoop results are combinational in the snoop
// cycle; state changes take effect at the next clock edge.
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W               = 12,
    parameter int IDX_W                = 3,
    parameter bit RD_FLUSH_INVALIDATES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_hit,
    output logic              snp_flush
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] look_idx;
    line_st_t         a_st, b_st, wr_st, upd_st;
    logic [TAG_W-1:0] a_tag, b_tag, wr_tag;
    logic             wr_en, upd_en;
    bus_op_t          fsm_op;

    assign bus_op = fsm_op;

    msi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (look_idx),
        .ra_st  (a_st),
        .ra_tag (a_tag),
        .rb_idx (snp_addr[IDX_W-1:0]),
        .rb_st  (b_st),
        .rb_tag (b_tag),
        .wa_en  (wr_en),
        .wa_idx (look_idx),
        .wa_st  (wr_st),
        .wa_tag (wr_tag),
        .wb_en  (upd_en),
        .wb_idx (snp_addr[IDX_W-1:0]),
        .wb_st  (upd_st)
    );

    msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_done (cpu_done),
        .look_idx (look_idx),
        .line_st  (a_st),
        .line_tag (a_tag),
        .bus_gnt  (bus_gnt),
        .bus_req  (bus_req),
        .bus_op   (fsm_op),
        .bus_addr (bus_addr),
        .wr_en    (wr_en),
        .wr_st    (wr_st),
        .wr_tag   (wr_tag)
    );

    msi_snoop_unit #(.TAG_W(TAG_W), .FLUSH_TO_INV(RD_FLUSH_INVALIDATES)) u_snoop (
        .snp_valid (snp_valid),
        .snp_op    (bus_op_t'(snp_op)),
        .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
        .line_st   (b_st),
        .line_tag  (b_tag),
        .hit       (snp_hit),
        .flush     (snp_flush),
        .upd_en    (upd_en),
        .upd_st    (upd_st)
    );
endmodule

// File: rtl/msi_line_chk.sv
// Port-level protocol checker for msi_line_ctrl, attached by bind.
module msi_line_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_done,
    input logic              bus_req,
    input logic [1:0]        bus_op,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              snp_valid,
    input logic [1:0]        snp_op,
    input logic              snp_hit,
    input logic              snp_flush
);
    AST_FLUSH_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> snp_hit); // R5

    AST_IGNORED_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!snp_valid || snp_op == 2'd0 || snp_op == 2'd3) |-> !snp_hit); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_op) && $stable(bus_addr))); // R11

    AST_DONE_WITH_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && bus_req) |-> (bus_gnt && (bus_op == 2'd1 || bus_op == 2'd2))); // R2

    AST_WB_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_op == 2'd3) |-> !cpu_done); // R10

    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> cpu_req); // R4

    AST_SNOOP_NOT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !(bus_req && bus_gnt)); // R12
endmodule

bind msi_line_ctrl msi_line_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_done  (cpu_done),
    .bus_req   (bus_req),
    .bus_op    (bus_op),
    .bus_addr  (bus_addr),
    .bus_gnt   (bus_gnt),
    .snp_valid (snp_valid),
    .snp_op    (snp_op),
    .snp_hit   (snp_hit),
    .snp_flush (snp_flush)
);

// File: tb/sim_msi_line_ctrl.sv
// Bench for msi_line_ctrl: directed corners plus seeded random traffic,
// checked against a reference state table kept here.
module sim_msi_line_ctrl;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 3;
    localparam int LINES  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_wr = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              bus_gnt = 1'b0;
    logic              snp_valid = 1'b0;
    logic [1:0]        snp_op = 2'd0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              u1_en = 1'b1;

    logic              cpu_done, bus_req, snp_hit, snp_flush;
    logic [1:0]        bus_op;
    logic [ADDR_W-1:0] bus_addr;
    logic              u1_done, u1_req, u1_hit, u1_flush;
    logic [1:0]        u1_op;
    logic [ADDR_W-1:0] u1_addr;

    int checks = 0;
    int errors = 0;
    int m_st  [LINES];   // 0 Invalid, 1 Shared, 2 Modified
    int m_tag [LINES];

    always #5 clk = ~clk;

    msi_line_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_done(cpu_done), .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_hit(snp_hit), .snp_flush(snp_flush)
    );

    msi_line_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RD_FLUSH_INVALIDATES(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req & u1_en), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_done(u1_done), .bus_req(u1_req), .bus_op(u1_op), .bus_addr(u1_addr),
        .bus_gnt(bus_gnt & u1_en), .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_hit(u1_hit), .snp_flush(u1_flush)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [ADDR_W-1:0] a);
        return int'(a[IDX_W-1:0]);
    endfunction

    function automatic int tag_of(input logic [ADDR_W-1:0] a);
        return int'(a[ADDR_W-1:IDX_W]);
    endfunction

    // Expected snoop result: {flush, hit, next state[1:0]}.
    function automatic logic [3:0] exp_snoop(input int op, input int st, input int tg, input int t);
        logic present;
        present = (st != 0) && (tg == t) && (op == 1 || op == 2);
        if (!present)           return {2'b00, 2'(st)};
        if (op == 2)            return {st == 2, 1'b1, 2'd0};
        if (st == 2)            return {2'b11, 2'd1};
        return {2'b01, 2'd1};
    endfunction

    // Wait for a bus request, compare it, stall, grant.
    task automatic wait_bus(input int op, input logic [ADDR_W-1:0] a, input int dly,
                            input bit exp_done, input string req);
        int n;
        n = 0;
        while (!bus_req && n < 8) begin
            @(negedge clk); #1; n++;
        end
        chk(bus_req == 1'b1, req, "bus_req raised", int'(bus_req), 1);
        chk(bus_op == 2'(op), req, "bus_op", int'(bus_op), op);
        chk(bus_addr == a, req, "bus_addr", int'(bus_addr), int'(a));
        for (int i = 0; i < dly; i++) begin
            @(negedge clk); #1;
            chk(bus_req && !cpu_done && bus_op == 2'(op), "R11", "stall hold", int'(bus_req), 1);
        end
        @(negedge clk);
        bus_gnt = 1'b1;
        #1;
        chk(cpu_done == exp_done, req, "cpu_done at grant", int'(cpu_done), int'(exp_done));
        @(negedge clk);
        bus_gnt = 1'b0;
        #1;
    endtask

    // One processor request, checked against the reference table.
    task automatic do_cpu(input bit wr, input logic [ADDR_W-1:0] a, input int dly);
        int i, t;
        bit hit;
        i = idx_of(a);
        t = tag_of(a);
        hit = (m_st[i] != 0) && (m_tag[i] == t) && (!wr || m_st[i] == 2);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a;
        #1;
        if (hit) begin
            chk(cpu_done && !bus_req, "R4", "hit done", int'(cpu_done), 1);
            @(negedge clk);
            cpu_req = 1'b0;
            #1;
        end else begin
            chk(!cpu_done, wr ? "R3" : "R2", "no done on miss", int'(cpu_done), 0);
            if (m_st[i] == 2 && m_tag[i] != t) begin
                wait_bus(3, {m_tag[i][ADDR_W-IDX_W-1:0], a[IDX_W-1:0]}, dly, 1'b0, "R10");
                m_st[i] = 0;
            end
            wait_bus(wr ? 2 : 1, a, dly, 1'b1, wr ? "R3" : "R2");
            cpu_req = 1'b0;
            m_st[i]  = wr ? 2 : 1;
            m_tag[i] = t;
        end
    endtask

    // One snooped transaction, checked against the reference table.
    task automatic do_snoop(input int op, input logic [ADDR_W-1:0] a);
        int i;
        logic [3:0] e;
        string rq;
        i = idx_of(a);
        e = exp_snoop(op, m_st[i], m_tag[i], tag_of(a));
        if (!e[2])                 rq = "R9";
        else if (op == 2)          rq = "R7";
        else if (m_st[i] == 2)     rq = "R5";
        else                       rq = "R8";
        @(negedge clk);
        snp_valid = 1'b1; snp_op = 2'(op); snp_addr = a;
        #1;
        chk(snp_hit == e[2], rq, "snp_hit", int'(snp_hit), int'(e[2]));
        chk(snp_flush == e[3], rq, "snp_flush", int'(snp_flush), int'(e[3]));
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        m_st[i] = int'(e[1:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a;
        void'($urandom(32'd1234));
        for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!bus_req && !cpu_done, "R1", "idle after reset", int'(bus_req), 0);
        do_snoop(2, 12'h000);
        do_snoop(1, 12'h007);

        // R6: policy variant, both instances in step until here
        do_cpu(1'b1, 12'h015, 0);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = 2'd1; snp_addr = 12'h015;
        #1;
        chk(snp_flush && u1_flush, "R6", "both flush", int'(u1_flush), 1);
        @(negedge clk);
        #1;
        chk(snp_hit && !snp_flush, "R5", "u0 now Shared", int'(snp_hit), 1);
        chk(!u1_hit, "R6", "u1 now Invalid", int'(u1_hit), 0);
        @(negedge clk);
        snp_valid = 1'b0;
        u1_en = 1'b0;
        m_st[5] = 1;

        // R4/R3: hits and upgrade from Shared
        do_cpu(1'b0, 12'h015, 0);
        do_cpu(1'b1, 12'h015, 2);
        do_cpu(1'b1, 12'h015, 0);
        do_cpu(1'b0, 12'h015, 0);

        // R7: read-to-own snoops on Modified then Shared
        do_snoop(2, 12'h015);
        do_cpu(1'b0, 12'h015, 1);
        do_snoop(2, 12'h015);
        do_cpu(1'b0, 12'h015, 0);
        do_snoop(1, 12'h015);

        // R9: mismatch and non-snooping codes leave the line alone
        do_snoop(1, 12'h025);
        do_snoop(3, 12'h015);
        do_snoop(0, 12'h015);
        do_cpu(1'b0, 12'h015, 0);

        // R10: dirty eviction, then clean replacement
        do_cpu(1'b1, 12'h00E, 0);
        do_cpu(1'b0, 12'h01E, 3);
        do_cpu(1'b1, 12'h026, 1);

        // R12: snoop removes the dirty victim while its writeback waits
        do_cpu(1'b1, 12'h017, 0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 12'h02F;
        @(negedge clk); #1;
        chk(bus_req && bus_op == 2'd3 && bus_addr == 12'h017, "R12", "victim wb pending",
            int'(bus_op), 3);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = 2'd1; snp_addr = 12'h017;
        #1;
        chk(snp_flush == 1'b1, "R12", "flush while pending", int'(snp_flush), 1);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(bus_req == 1'b0, "R12", "writeback withdrawn", int'(bus_req), 0);
        wait_bus(1, 12'h02F, 1, 1'b1, "R12");
        cpu_req = 1'b0;
        m_st[7] = 1; m_tag[7] = 5;

        // Seeded random traffic
        for (int it = 0; it < 400; it++) begin
            a = {9'($urandom % 3), 3'($urandom % 4)};
            if ($urandom % 10 < 6) do_cpu(1'($urandom % 2), a, int'($urandom % 4));
            else                    do_snoop(int'($urandom % 4), a);
        end

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule